// File: doc/BRIEF.md
# Canonic signed-digit recoder with shift-and-add check path

This block takes an unsigned binary constant and rewrites it as a vector of signed digits, each digit being -1, 0 or +1. The vector comes out as two masks of equal width, one marking the +1 positions and one marking the -1 positions. A constant of W bits yields W+1 digits, because the rewrite can carry one place past the top input bit.

Two recoding modes are offered. The canonic mode gives the unique non-adjacent form: no two neighbouring digits are nonzero, which also makes the count of nonzero digits as small as it can be. The fewer-negatives mode begins from the canonic vector and then turns each "+1, 0, -1" window into "0, +1, +1". The value and the nonzero count stay the same, and one negated partial product is saved for each window. This matters because every -1 digit costs an inverted multiplicand plus a carried-in one.

A combinational shift-and-add path multiplies a runtime operand by the selected digit vector. It adds a shifted copy of the operand for each +1 digit. For each -1 digit it adds the inverted shifted copy and a one at the least significant bit. The product it returns must equal operand times constant in either mode, which shows that the recoding preserves the value.

Top module: `csdRecoder`

## Requirements
- R1: Digit i is +1 when posMask[i]=1, -1 when negMask[i]=1, and 0 when both are 0. Bit i of each mask weighs 2^i. posMask[i] and negMask[i] are never both 1.
- R2: In both modes, the sum over i of digit(i)·2^i equals constIn.
- R3: In canonic mode (modeSel=0), no two adjacent digits are both nonzero.
- R4: In canonic mode, the digit vector equals the unique non-adjacent signed-digit form of constIn.
- R5: In fewer-negatives mode (modeSel=1), the digits equal the canonic digits with one change. Every window where the canonic digits at positions i+2, i+1, i read +1, 0, -1 reads 0, +1, +1 instead. Windows are judged on the canonic digits.
- R6: Fewer-negatives mode has the same nonzero-digit count as canonic mode for the same constant, and never more -1 digits.
- R7: The top digit (index W) is never -1. A zero constant gives all-zero masks.
- R8: product equals operand × constIn exactly, over W+OW bits, in both modes.
- R9: With constIn and operand held, changing modeSel leaves product unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| constIn | input | W | Unsigned constant to recode |
| modeSel | input | 1 | 0 = canonic, 1 = fewer negative digits |
| operand | input | OW | Unsigned runtime multiplicand |
| posMask | output | W+1 | Positions holding a +1 digit |
| negMask | output | W+1 | Positions holding a -1 digit |
| product | output | W+OW | operand × constIn, built from the digits |

## Verification
Recoding and multiplication settle together: a single change to constIn or modeSel alters the digit masks and the product in the same evaluation. A mode flip is the case where the digits change while the product must not. To provoke it, every constant of the default width is applied in canonic mode and then in fewer-negatives mode with the operand held. The bench compares each pair of products with each other and with the exact product. It also compares both digit vectors with a non-adjacent form that it derives by integer division.

// File: rtl/csdPkg.sv
package csdPkg;

  typedef enum logic {
    MODE_CANON  = 1'b0,
    MODE_FEWNEG = 1'b1
  } recodeModeE;

  // one signed digit as two strobes from recoder to datapath
  typedef struct packed {
    logic pos;
    logic neg;
  } digitT;

endpackage

// File: rtl/csdRecodeCtrl.sv
module csdRecodeCtrl
  import csdPkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] constIn,
  input  recodeModeE   mode,
  output digitT        digits [W+1]
);

  localparam int ND = W + 1;   // digit count
  localparam int XW = W + 2;   // padded input width

  always_comb begin
    logic [XW-1:0] x;
    logic [XW-1:0] carry;
    logic [ND-1:0] canonPos, canonNeg, modPos, modNeg, canonNz, selPos, selNeg;
    logic [XW-1:0] valSum;
    int            cntCanon, cntMod, negCanon, negMod;

    x        = {2'b00, constIn};
    carry    = '0;
    canonPos = '0;
    canonNeg = '0;
    // carry chain: digit = x + carryIn - 2*carryOut
    for (int i = 0; i < ND; i++) begin
      carry[i+1]  = (x[i] & x[i+1]) | ((x[i] | x[i+1]) & carry[i]);
      canonPos[i] = (x[i] ^ carry[i]) & ~carry[i+1];
      canonNeg[i] = (x[i] ^ carry[i]) &  carry[i+1];
    end
    canonNz = canonPos | canonNeg;

    // fewer-negatives rewrite: +1,0,-1 -> 0,+1,+1 (windows never overlap)
    modPos = canonPos;
    modNeg = canonNeg;
    for (int i = 0; i + 2 < ND; i++) begin
      if (canonPos[i+2] && !canonNz[i+1] && canonNeg[i]) begin
        modPos[i+2] = 1'b0;
        modPos[i+1] = 1'b1;
        modPos[i]   = 1'b1;
        modNeg[i]   = 1'b0;
      end
    end

    selPos = (mode == MODE_FEWNEG) ? modPos : canonPos;
    selNeg = (mode == MODE_FEWNEG) ? modNeg : canonNeg;
    for (int i = 0; i < ND; i++) begin
      digits[i].pos = selPos[i];
      digits[i].neg = selNeg[i];
    end

    valSum   = '0;
    cntCanon = 0;
    cntMod   = 0;
    negCanon = 0;
    negMod   = 0;
    for (int i = 0; i < ND; i++) begin
      if (selPos[i]) valSum = valSum + (XW'(1) << i);
      if (selNeg[i]) valSum = valSum - (XW'(1) << i);
      cntCanon = cntCanon + int'(canonNz[i]);
      cntMod   = cntMod + int'(modPos[i] | modNeg[i]);
      negCanon = negCanon + int'(canonNeg[i]);
      negMod   = negMod + int'(modNeg[i]);
    end

    AST_DIGIT_LEGAL: assert ((selPos & selNeg) == '0)
      else $error("digit with both strobes set"); // R1
    AST_VALUE_KEPT: assert (valSum == XW'(constIn))
      else $error("digit vector value differs from constant"); // R2
    AST_CANON_SPARSE: assert ((canonNz[ND-1:1] & canonNz[ND-2:0]) == '0)
      else $error("adjacent nonzero canonic digits"); // R3
    AST_FEWNEG_COUNT: assert (cntMod == cntCanon && negMod <= negCanon)
      else $error("rewrite changed digit count or added negatives"); // R6
    AST_TOP_NOT_NEG: assert (!selNeg[ND-1])
      else $error("top digit negative"); // R7
  end

endmodule

// File: rtl/csdMulPath.sv
module csdMulPath
  import csdPkg::*;
#(
  parameter int W  = 8,
  parameter int OW = 8
) (
  input  logic [OW-1:0]   operand,
  input  digitT           digits [W+1],
  output logic [W+OW-1:0] product
);

  localparam int ND = W + 1;
  localparam int PW = W + OW;

  logic [PW-1:0] termVal [ND];
  logic [ND-1:0] negOne;

  for (genvar g = 0; g < ND; g++) begin : gTerm
    logic [PW-1:0] shifted;
    assign shifted   = PW'(operand) << g;
    assign termVal[g] = digits[g].pos ? shifted :
                        digits[g].neg ? ~shifted : '0;
    assign negOne[g]  = digits[g].neg;
  end

  always_comb begin
    logic [PW-1:0] acc;
    logic [PW-1:0] digVal;
    acc = '0;
    for (int i = 0; i < ND; i++) begin
      acc = acc + termVal[i];
      acc = acc + PW'(negOne[i]);   // the +1 that completes each negation
    end
    product = acc;

    digVal = '0;
    for (int i = 0; i < ND; i++) begin
      if (digits[i].pos) digVal = digVal + (PW'(1) << i);
      if (digits[i].neg) digVal = digVal - (PW'(1) << i);
    end
    AST_PRODUCT_MATCH: assert (acc == PW'(operand) * digVal)
      else $error("shift-and-add product mismatch"); // R8
  end

endmodule

// File: rtl/csdRecoder.sv
module csdRecoder
  import csdPkg::*;
#(
  parameter int W  = 8,
  parameter int OW = 8
) (
  input  logic [W-1:0]    constIn,
  input  logic            modeSel,
  input  logic [OW-1:0]   operand,
  output logic [W:0]      posMask,
  output logic [W:0]      negMask,
  output logic [W+OW-1:0] product
);

  localparam int ND = W + 1;

  digitT      digits [ND];
  recodeModeE mode;

  assign mode = recodeModeE'(modeSel);

  csdRecodeCtrl #(.W(W)) ctrl_i (
    .constIn (constIn),
    .mode    (mode),
    .digits  (digits)
  );

  csdMulPath #(.W(W), .OW(OW)) path_i (
    .operand (operand),
    .digits  (digits),
    .product (product)
  );

  for (genvar g = 0; g < ND; g++) begin : gMask
    assign posMask[g] = digits[g].pos;
    assign negMask[g] = digits[g].neg;
  end

endmodule

// File: tb/csdRecoder_tb_top.sv
module csdRecoder_tb_top;

  localparam int W  = 8;
  localparam int OW = 8;
  localparam int ND = W + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [W-1:0]    constIn = '0;
  logic            modeSel = 1'b0;
  logic [OW-1:0]   operand = '0;
  logic [W:0]      posMask, negMask;
  logic [W+OW-1:0] product;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  csdRecoder #(.W(W), .OW(OW)) dut_i (
    .constIn (constIn),
    .modeSel (modeSel),
    .operand (operand),
    .posMask (posMask),
    .negMask (negMask),
    .product (product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // non-adjacent form by repeated division
  task automatic refDigits(input int c, input bit fewNeg, output int d [ND]);
    int n;
    int canon [ND];
    n = c;
    for (int i = 0; i < ND; i++) begin
      if (n % 2 != 0) begin
        canon[i] = (n % 4 == 1) ? 1 : -1;
        n = (n - canon[i]) / 2;
      end else begin
        canon[i] = 0;
        n = n / 2;
      end
    end
    d = canon;
    if (fewNeg) begin
      for (int i = 0; i + 2 < ND; i++) begin
        if (canon[i+2] == 1 && canon[i+1] == 0 && canon[i] == -1) begin
          d[i+2] = 0; d[i+1] = 1; d[i] = 1;
        end
      end
    end
  endtask

  task automatic applyAndCheck(input int c, input bit m, input int op, input longint prevProd, input bit cmpPrev,
                               output longint gotProd);
    int d [ND];
    int canon [ND];
    longint expPos, expNeg, sumVal, expProd;
    int nzRef, negRef, nzGot, negGot;
    bit adjOk;
    @(posedge clk);
    constIn = W'(c);
    modeSel = m;
    operand = OW'(op);
    @(negedge clk);
    refDigits(c, m, d);
    refDigits(c, 1'b0, canon);
    expPos = 0; expNeg = 0; nzRef = 0; negRef = 0;
    for (int i = 0; i < ND; i++) begin
      if (d[i] == 1)  expPos |= (64'(1) << i);
      if (d[i] == -1) expNeg |= (64'(1) << i);
      if (canon[i] != 0) nzRef++;
      if (canon[i] == -1) negRef++;
    end
    if (!m) begin
      check(posMask == (W+1)'(expPos), "R4 canonic +1 mask", longint'(posMask), expPos);
      check(negMask == (W+1)'(expNeg), "R4 canonic -1 mask", longint'(negMask), expNeg);
    end else begin
      check(posMask == (W+1)'(expPos), "R5 fewer-neg +1 mask", longint'(posMask), expPos);
      check(negMask == (W+1)'(expNeg), "R5 fewer-neg -1 mask", longint'(negMask), expNeg);
    end
    check((posMask & negMask) == '0, "R1 both strobes", longint'(posMask & negMask), 0);
    sumVal = 0; nzGot = 0; negGot = 0; adjOk = 1'b1;
    for (int i = 0; i < ND; i++) begin
      if (posMask[i]) sumVal += (64'(1) << i);
      if (negMask[i]) begin sumVal -= (64'(1) << i); negGot++; end
      if (posMask[i] | negMask[i]) nzGot++;
      if (i > 0 && (posMask[i] | negMask[i]) && (posMask[i-1] | negMask[i-1])) adjOk = 1'b0;
    end
    check(sumVal == longint'(c), "R2 digit value", sumVal, c);
    if (!m) check(adjOk, "R3 adjacent nonzero", 1, 0);
    else begin
      check(nzGot == nzRef, "R6 nonzero count", nzGot, nzRef);
      check(negGot <= negRef, "R6 negative count", negGot, negRef);
    end
    check(!negMask[W], "R7 top digit", longint'(negMask[W]), 0);
    expProd = longint'(c) * longint'(op);
    check(longint'(product) == expProd, "R8 product", longint'(product), expProd);
    if (cmpPrev) check(longint'(product) == prevProd, "R9 product across mode flip", longint'(product), prevProd);
    gotProd = longint'(product);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    longint p0, p1;
    int ops [4];
    // R7: zero constant at start
    @(negedge clk);
    check(posMask == '0, "R7 zero constant +1 mask", longint'(posMask), 0);
    check(negMask == '0, "R7 zero constant -1 mask", longint'(negMask), 0);
    check(product == '0, "R8 zero product", longint'(product), 0);
    // spot value: 3 -> canonic 4-1, fewer-neg 2+1
    applyAndCheck(3, 1'b0, 5, 0, 1'b0, p0);
    check(negMask == 9'b000000001, "R4 constant 3 canonic", longint'(negMask), 1);
    applyAndCheck(3, 1'b1, 5, p0, 1'b1, p1);
    check(posMask == 9'b000000011 && negMask == '0, "R5 constant 3 kept", longint'(posMask), 3);
    // exhaustive constants, varied operands, both modes
    for (int c = 0; c < (1 << W); c++) begin
      ops[0] = 0;
      ops[1] = (1 << OW) - 1;
      ops[2] = 1;
      ops[3] = int'($urandom_range((1 << OW) - 1, 0));
      for (int k = 0; k < 4; k++) begin
        applyAndCheck(c, 1'b0, ops[k], 0, 1'b0, p0);
        applyAndCheck(c, 1'b1, ops[k], p0, 1'b1, p1);
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule